// File: doc/BRIEF.md
# Quad-Word Burst Limiter

This block watches the beats of a burst that a main-bus master issues towards an SDRAM slave. The SDRAM side always moves one whole quad word (four 32-bit words, eight half-word accesses) per request. The limiter decides, in the same cycle as each beat, whether that beat must be the final one of the burst. It raises a last-beat flag at quad-word boundaries, after four word beats, and on every byte or half-word beat. The bus decoder uses that flag to break the burst.

When a new tracking window opens, the block registers the order in which the SDRAM words and half-words of the quad word should be fetched. The order starts at the word the master addressed and wraps around the quad word. When the window closes, it reports which words the master actually touched and which byte lanes. Untouched words are surplus: read data for them is dropped, and write beats for them are masked.

Transfer size encoding on `beat_size`: 0 = byte, 1 = half-word, 2 or 3 = word. The word within the quad word is `beat_addr[3:2]`. The byte within the word is `beat_addr[1:0]`.

Top module: `qw_burst_limiter`

## Requirements
- R1: A word-sized beat (beat_size 2 or 3) whose address has bits [3:2] equal to 3 raises beat_last in the same cycle, whatever the start alignment of its burst.
- R2: The fourth beat of a tracking window raises beat_last, even if its address is not at a quad-word boundary.
- R3: Every beat with beat_size 0 (byte) or 1 (half-word) raises beat_last in the same cycle, sequential or not.
- R4: beat_last is high only in a cycle where beat_valid is high, and only for the beat that meets R1, R2 or R3.
- R5: A window opens on a beat with beat_seq low, on a sequential beat when no window is open, and on any beat that follows a last beat. plan_valid is high in the cycle after an opening beat, and low after a cycle without one.
- R6: plan_word_order slot k (bits [2k+1:2k]) holds (s + k) mod 4, where s is beat_addr[3:2] of the opening beat.
- R7: plan_hw_order slot j (bits [3j+2:3j]) holds 2*w + (j mod 2), where w is word-order slot j/2.
- R8: A window closes in a cycle that is idle or that opens a new window. rpt_valid is high in the cycle after the closure, and only for that cycle per closure.
- R9: rpt_keep bit w is set exactly when a beat of the closed window addressed word w. The clear bits mark surplus SDRAM words.
- R10: rpt_lane_en bit 4w+b is set when a beat of the window touched byte b of word w. A word beat touches all four bytes. A half-word beat touches bytes 2*addr[1] and 2*addr[1]+1. A byte beat touches byte addr[1:0]. rpt_write equals beat_write of the opening beat.
- R11: While reset is applied, and until the window state has restarted, plan_valid and rpt_valid are low. A window open at reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_valid | input | 1 | A transfer beat is on the bus this cycle |
| beat_addr | input | ADDR_W (32) | Byte address of the beat |
| beat_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| beat_seq | input | 1 | Beat continues the current burst |
| beat_write | input | 1 | Beat is a write |
| beat_last | output | 1 | This beat must end the burst |
| plan_valid | output | 1 | Fetch order registers hold a new plan |
| plan_word_order | output | 8 | Four 2-bit word indices, slot 0 in the low bits |
| plan_hw_order | output | 24 | Eight 3-bit half-word indices, slot 0 in the low bits |
| rpt_valid | output | 1 | A window has closed; report fields are valid |
| rpt_write | output | 1 | Closed window was a write |
| rpt_keep | output | 4 | Words requested by the master in the closed window |
| rpt_lane_en | output | 16 | Byte lanes requested, 4 per word |

## Verification
The bench drives bursts that start on each word of the quad word, as well as single-beat and short bursts. It checks that the break lands exactly on word 3. A design that counted beats instead of reading the address would break misaligned bursts late and overrun the boundary. A burst that repeats one word address tests the four-beat cap. A design without that cap would let such a burst run on forever. Other cases are a sequential beat that arrives after a break, a sequential beat with no window open, and back-to-back bursts with no idle cycle between them. A design that merged windows there would report the wrong keep and lane masks, or drop a report. Sub-word writes at odd offsets catch a lane mask shifted by the wrong amount. A reset in the middle of a window catches stale reports.

// File: rtl/qbl_pkg.sv
package qbl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/qbl_rst_sync.sv
module qbl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/qbl_order_gen.sv
module qbl_order_gen #(
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic [$clog2(LINE_WORDS)-1:0]                     start_idx,
  output logic [LINE_WORDS*$clog2(LINE_WORDS)-1:0]          word_order,
  output logic [2*LINE_WORDS*($clog2(LINE_WORDS)+1)-1:0]    hw_order
);

  localparam int unsigned WIDX_W = $clog2(LINE_WORDS);
  localparam int unsigned HIDX_W = WIDX_W + 1;

  // word slots wrap around the line, starting at the addressed word
  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word_slot
    assign word_order[k*WIDX_W +: WIDX_W] = start_idx + WIDX_W'(k);
  end

  // two half-word accesses per word, low half first
  for (genvar j = 0; j < 2*LINE_WORDS; j++) begin : g_hw_slot
    assign hw_order[j*HIDX_W +: HIDX_W] =
      {word_order[(j/2)*WIDX_W +: WIDX_W], 1'(j % 2)};
  end

endmodule

// File: rtl/qbl_lane_mask.sv
module qbl_lane_mask
  import qbl_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic [$clog2(LINE_WORDS)-1:0]     word_idx,
  input  logic [1:0]                        byte_ofs,
  input  logic [1:0]                        size,
  output logic [LINE_WORDS*WORD_BYTES-1:0]  lanes
);

  localparam int unsigned LANES = LINE_WORDS * WORD_BYTES;

  logic [WORD_BYTES-1:0] word_lanes;

  always_comb begin
    case (size)
      SZ_BYTE: word_lanes = 4'b0001 << byte_ofs;
      SZ_HALF: word_lanes = byte_ofs[1] ? 4'b1100 : 4'b0011;
      default: word_lanes = 4'b1111;
    endcase
    lanes = LANES'(word_lanes) << {word_idx, 2'b00};
  end

endmodule

// File: rtl/qbl_window_track.sv
module qbl_window_track
  import qbl_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                beat_valid,
  input  logic                                beat_seq,
  input  logic                                beat_write,
  input  logic                                sub_word,
  input  logic [$clog2(LINE_WORDS)-1:0]       word_idx,
  input  logic [LINE_WORDS*WORD_BYTES-1:0]    beat_lanes,
  output logic                                beat_last,
  output logic                                win_start,
  output logic                                rpt_valid,
  output logic                                rpt_write,
  output logic [LINE_WORDS-1:0]               rpt_keep,
  output logic [LINE_WORDS*WORD_BYTES-1:0]    rpt_lane_en
);

  localparam int unsigned WIDX_W = $clog2(LINE_WORDS);
  localparam int unsigned LANES  = LINE_WORDS * WORD_BYTES;
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(LINE_WORDS - 1);

  // window state
  logic              open_q,  open_d;
  logic              last_q,  last_d;
  logic [WIDX_W-1:0] cnt_q,   cnt_d;
  logic [LINE_WORDS-1:0] keep_q, keep_d;
  logic [LANES-1:0]  lanes_q, lanes_d;
  logic              wr_q,    wr_d;

  // report state
  logic              rpt_valid_q;
  logic              rpt_write_q;
  logic [LINE_WORDS-1:0] rpt_keep_q;
  logic [LANES-1:0]  rpt_lanes_q;

  logic              close_win;
  logic [WIDX_W-1:0] cnt_eff;
  logic [LINE_WORDS-1:0] word_hit;

  always_comb begin
    win_start = beat_valid & (~beat_seq | ~open_q | last_q);
    cnt_eff   = win_start ? '0 : cnt_q;
    beat_last = beat_valid & (sub_word | (word_idx == LAST_IDX) | (cnt_eff == LAST_IDX));
    close_win = open_q & (~beat_valid | win_start);
    word_hit  = LINE_WORDS'(1) << word_idx;

    open_d = beat_valid;
    last_d = beat_last;
    cnt_d  = beat_valid ? cnt_eff + WIDX_W'(1) : '0;
    wr_d   = win_start ? beat_write : wr_q;

    if (!beat_valid) begin
      keep_d  = '0;
      lanes_d = '0;
    end else if (win_start) begin
      keep_d  = word_hit;
      lanes_d = beat_lanes;
    end else begin
      keep_d  = keep_q | word_hit;
      lanes_d = lanes_q | beat_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      keep_q  <= '0;
      lanes_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      open_q  <= open_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      keep_q  <= keep_d;
      lanes_q <= lanes_d;
      wr_q    <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid_q <= 1'b0;
      rpt_write_q <= 1'b0;
      rpt_keep_q  <= '0;
      rpt_lanes_q <= '0;
    end else begin
      rpt_valid_q <= close_win;
      if (close_win) begin
        rpt_write_q <= wr_q;
        rpt_keep_q  <= keep_q;
        rpt_lanes_q <= lanes_q;
      end
    end
  end

  assign rpt_valid   = rpt_valid_q;
  assign rpt_write   = rpt_write_q;
  assign rpt_keep    = rpt_keep_q;
  assign rpt_lane_en = rpt_lanes_q;

endmodule

// File: rtl/qw_burst_limiter.sv
module qw_burst_limiter
  import qbl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           beat_valid,
  input  logic [ADDR_W-1:0]                              beat_addr,
  input  logic [1:0]                                     beat_size,
  input  logic                                           beat_seq,
  input  logic                                           beat_write,
  output logic                                           beat_last,
  output logic                                           plan_valid,
  output logic [LINE_WORDS*$clog2(LINE_WORDS)-1:0]       plan_word_order,
  output logic [2*LINE_WORDS*($clog2(LINE_WORDS)+1)-1:0] plan_hw_order,
  output logic                                           rpt_valid,
  output logic                                           rpt_write,
  output logic [LINE_WORDS-1:0]                          rpt_keep,
  output logic [LINE_WORDS*4-1:0]                        rpt_lane_en
);

  localparam int unsigned WIDX_W  = $clog2(LINE_WORDS);
  localparam int unsigned HIDX_W  = WIDX_W + 1;
  localparam int unsigned WORD_W  = LINE_WORDS * WIDX_W;
  localparam int unsigned HW_W    = 2 * LINE_WORDS * HIDX_W;
  localparam int unsigned LANES   = LINE_WORDS * WORD_BYTES;
  localparam int unsigned IDX_LSB = $clog2(WORD_BYTES);

  logic                 rst_n_int;
  logic [WIDX_W-1:0]    word_idx;
  logic                 sub_word;
  logic [LANES-1:0]     beat_lanes;
  logic                 win_start;
  logic [WORD_W-1:0]    gen_word_order;
  logic [HW_W-1:0]      gen_hw_order;
  logic                 plan_valid_q;
  logic [WORD_W-1:0]    plan_word_q;
  logic [HW_W-1:0]      plan_hw_q;
  logic                 unused_addr_hi;

  assign word_idx       = beat_addr[IDX_LSB +: WIDX_W];
  assign sub_word       = (beat_size == SZ_BYTE) | (beat_size == SZ_HALF);
  assign unused_addr_hi = ^beat_addr[ADDR_W-1:IDX_LSB+WIDX_W];

  qbl_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  qbl_lane_mask #(.LINE_WORDS(LINE_WORDS)) u_lane_mask (
    .word_idx (word_idx),
    .byte_ofs (beat_addr[1:0]),
    .size     (beat_size),
    .lanes    (beat_lanes)
  );

  qbl_order_gen #(.LINE_WORDS(LINE_WORDS)) u_order_gen (
    .start_idx  (word_idx),
    .word_order (gen_word_order),
    .hw_order   (gen_hw_order)
  );

  qbl_window_track #(.LINE_WORDS(LINE_WORDS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .beat_valid  (beat_valid),
    .beat_seq    (beat_seq),
    .beat_write  (beat_write),
    .sub_word    (sub_word),
    .word_idx    (word_idx),
    .beat_lanes  (beat_lanes),
    .beat_last   (beat_last),
    .win_start   (win_start),
    .rpt_valid   (rpt_valid),
    .rpt_write   (rpt_write),
    .rpt_keep    (rpt_keep),
    .rpt_lane_en (rpt_lane_en)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      plan_valid_q <= 1'b0;
      plan_word_q  <= '0;
      plan_hw_q    <= '0;
    end else begin
      plan_valid_q <= win_start;
      if (win_start) begin
        plan_word_q <= gen_word_order;
        plan_hw_q   <= gen_hw_order;
      end
    end
  end

  assign plan_valid      = plan_valid_q;
  assign plan_word_order = plan_word_q;
  assign plan_hw_order   = plan_hw_q;

endmodule

// File: rtl/qbl_checker.sv
module qbl_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_WORDS = 4
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     beat_valid,
  input logic [ADDR_W-1:0]                        beat_addr,
  input logic [1:0]                               beat_size,
  input logic                                     beat_last,
  input logic                                     plan_valid,
  input logic [LINE_WORDS*$clog2(LINE_WORDS)-1:0] plan_word_order,
  input logic                                     rpt_valid,
  input logic [LINE_WORDS-1:0]                    rpt_keep,
  input logic [LINE_WORDS*4-1:0]                  rpt_lane_en
);

  localparam int unsigned WIDX_W = $clog2(LINE_WORDS);

  logic [WIDX_W-1:0]     chk_widx;
  logic [LINE_WORDS-1:0] lane_words;
  logic                  unused_chk;

  assign chk_widx   = beat_addr[2 +: WIDX_W];
  assign unused_chk = ^{beat_addr[ADDR_W-1:2+WIDX_W], beat_addr[1:0]};

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane_word
    assign lane_words[w] = |rpt_lane_en[4*w +: 4];
  end

  p_last_needs_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  p_sub_word_breaks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_size < 2'd2) |-> beat_last);

  p_boundary_breaks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_size >= 2'd2 && chk_widx == WIDX_W'(LINE_WORDS-1)) |-> beat_last);

  p_plan_after_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid |-> $past(beat_valid));

  p_order_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid |-> (plan_word_order[WIDX_W +: WIDX_W] == plan_word_order[0 +: WIDX_W] + WIDX_W'(1)));

  p_report_history_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(beat_valid, 2));

  p_keep_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_keep != '0));

  p_lanes_match_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (lane_words == rpt_keep));

endmodule

bind qw_burst_limiter qbl_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_WORDS (LINE_WORDS)
) u_qbl_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .beat_valid      (beat_valid),
  .beat_addr       (beat_addr),
  .beat_size       (beat_size),
  .beat_last       (beat_last),
  .plan_valid      (plan_valid),
  .plan_word_order (plan_word_order),
  .rpt_valid       (rpt_valid),
  .rpt_keep        (rpt_keep),
  .rpt_lane_en     (rpt_lane_en)
);

// File: tb/test_qw_burst_limiter.sv
`timescale 1ns/1ps
module test_qw_burst_limiter;

  logic        clk;
  logic        rst_n;
  logic        beat_valid;
  logic [31:0] beat_addr;
  logic [1:0]  beat_size;
  logic        beat_seq;
  logic        beat_write;
  logic        beat_last;
  logic        plan_valid;
  logic [7:0]  plan_word_order;
  logic [23:0] plan_hw_order;
  logic        rpt_valid;
  logic        rpt_write;
  logic [3:0]  rpt_keep;
  logic [15:0] rpt_lane_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  qw_burst_limiter i_qw_burst_limiter (
    .clk             (clk),
    .rst_n           (rst_n),
    .beat_valid      (beat_valid),
    .beat_addr       (beat_addr),
    .beat_size       (beat_size),
    .beat_seq        (beat_seq),
    .beat_write      (beat_write),
    .beat_last       (beat_last),
    .plan_valid      (plan_valid),
    .plan_word_order (plan_word_order),
    .plan_hw_order   (plan_hw_order),
    .rpt_valid       (rpt_valid),
    .rpt_write       (rpt_write),
    .rpt_keep        (rpt_keep),
    .rpt_lane_en     (rpt_lane_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [2:0]  nbeats;
    logic        wr;
    logic [2:0]  last_idx;   // 7 = no beat ends the burst
    logic [3:0]  keep;
    logic [15:0] lanes;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{32'h100, 2'd2, 3'd4, 1'b0, 3'd3, 4'hF, 16'hFFFF},
    '{32'h104, 2'd2, 3'd3, 1'b1, 3'd2, 4'hE, 16'hFFF0},
    '{32'h108, 2'd2, 3'd2, 1'b0, 3'd1, 4'hC, 16'hFF00},
    '{32'h200, 2'd2, 3'd2, 1'b1, 3'd7, 4'h3, 16'h00FF},
    '{32'h20E, 2'd1, 3'd1, 1'b1, 3'd0, 4'h8, 16'hC000},
    '{32'h205, 2'd0, 3'd1, 1'b1, 3'd0, 4'h2, 16'h0020},
    '{32'h30C, 2'd2, 3'd1, 1'b0, 3'd0, 4'h8, 16'hF000},
    '{32'h304, 2'd2, 3'd1, 1'b0, 3'd7, 4'h2, 16'h00F0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_words(input logic [1:0] st);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) r[2*k +: 2] = st + 2'(k);
    return r;
  endfunction

  function automatic logic [23:0] exp_hws(input logic [1:0] st);
    logic [23:0] r;
    for (int j = 0; j < 8; j++) r[3*j +: 3] = {2'(st + 2'(j/2)), 1'(j % 2)};
    return r;
  endfunction

  task automatic beat(input logic [31:0] a, input logic [1:0] s, input bit sq, input bit w);
    @(negedge clk);
    beat_valid = 1'b1;
    beat_addr  = a;
    beat_size  = s;
    beat_seq   = sq;
    beat_write = w;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    beat_valid = 1'b0;
    beat_seq   = 1'b0;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic check_plan(input logic [1:0] st, input string tag);
    chk(plan_valid == 1'b1, "R5", {tag, " plan_valid"}, 32'(plan_valid), 32'd1);
    chk(plan_word_order == exp_words(st), "R6", {tag, " word order"},
        32'(plan_word_order), 32'(exp_words(st)));
    chk(plan_hw_order == exp_hws(st), "R7", {tag, " half-word order"},
        32'(plan_hw_order), 32'(exp_hws(st)));
  endtask

  task automatic check_rpt(input logic [3:0] k, input logic [15:0] l, input bit w, input string tag);
    chk(rpt_valid == 1'b1, "R8", {tag, " rpt_valid"}, 32'(rpt_valid), 32'd1);
    chk(rpt_keep == k, "R9", {tag, " keep"}, 32'(rpt_keep), 32'(k));
    chk(rpt_lane_en == l, "R10", {tag, " lanes"}, 32'(rpt_lane_en), 32'(l));
    chk(rpt_write == w, "R10", {tag, " write flag"}, 32'(rpt_write), 32'(w));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    beat_valid = 1'b0;
    beat_addr  = '0;
    beat_size  = 2'd2;
    beat_seq   = 1'b0;
    beat_write = 1'b0;
    rst_n      = 1'b0;

    // R11: quiet during reset
    repeat (3) @(posedge clk);
    #1;
    chk(plan_valid == 1'b0, "R11", "plan_valid in reset", 32'(plan_valid), 32'd0);
    chk(rpt_valid == 1'b0, "R11", "rpt_valid in reset", 32'(rpt_valid), 32'd0);
    chk(beat_last == 1'b0, "R4", "beat_last with no beat", 32'(beat_last), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table-driven bursts
    for (int v = 0; v < NVEC; v++) begin
      automatic vec_t t = TBL[v];
      automatic int unsigned step = (t.size == 2'd0) ? 1 : (t.size == 2'd1) ? 2 : 4;
      automatic string tag = $sformatf("vec%0d", v);
      for (int b = 0; b < int'(t.nbeats); b++) begin
        beat(t.addr + 32'(b) * step, t.size, b != 0, t.wr);
        chk(beat_last == (b == int'(t.last_idx)),
            (t.size < 2'd2) ? "R3" : "R1", $sformatf("%s beat%0d last", tag, b),
            32'(beat_last), 32'(b == int'(t.last_idx)));
        if (b == 0) begin
          after_edge();
          check_plan(t.addr[3:2], tag);
        end
      end
      idle();
      after_edge();
      check_rpt(t.keep, t.lanes, t.wr, tag);
      idle();
      after_edge();
      chk(rpt_valid == 1'b0, "R8", {tag, " report pulse ends"}, 32'(rpt_valid), 32'd0);
      chk(plan_valid == 1'b0, "R5", {tag, " plan idle"}, 32'(plan_valid), 32'd0);
    end

    // R2: four beats on one word address, then a sequential beat after the break
    for (int b = 0; b < 4; b++) begin
      beat(32'h400, 2'd2, b != 0, 1'b0);
      chk(beat_last == (b == 3), "R2", $sformatf("cap beat%0d", b), 32'(beat_last), 32'(b == 3));
    end
    beat(32'h400, 2'd2, 1'b1, 1'b0);
    chk(beat_last == 1'b0, "R2", "count restarts after break", 32'(beat_last), 32'd0);
    after_edge();
    check_plan(2'd0, "seq after last");
    check_rpt(4'h1, 16'h000F, 1'b0, "capped window");
    idle();
    after_edge();
    check_rpt(4'h1, 16'h000F, 1'b0, "window after break");

    // R5: sequential beat with no window open starts one
    idle();
    beat(32'h508, 2'd2, 1'b1, 1'b1);
    chk(beat_last == 1'b0, "R4", "word 2 not a break", 32'(beat_last), 32'd0);
    after_edge();
    check_plan(2'd2, "orphan seq");
    idle();
    after_edge();
    check_rpt(4'h4, 16'h0F00, 1'b1, "orphan seq");

    // R8: back-to-back bursts without idle
    idle();
    beat(32'h60C, 2'd2, 1'b0, 1'b0);
    chk(beat_last == 1'b1, "R1", "b2b first last", 32'(beat_last), 32'd1);
    beat(32'h602, 2'd1, 1'b0, 1'b1);
    chk(beat_last == 1'b1, "R3", "b2b half last", 32'(beat_last), 32'd1);
    after_edge();
    check_plan(2'd0, "b2b second");
    check_rpt(4'h8, 16'hF000, 1'b0, "b2b first");
    idle();
    after_edge();
    check_rpt(4'h1, 16'h000C, 1'b1, "b2b second");

    // R3: sequential byte beats each break
    idle();
    beat(32'h701, 2'd0, 1'b0, 1'b0);
    chk(beat_last == 1'b1, "R3", "byte beat0", 32'(beat_last), 32'd1);
    beat(32'h702, 2'd0, 1'b1, 1'b0);
    chk(beat_last == 1'b1, "R3", "seq byte beat1", 32'(beat_last), 32'd1);
    idle();
    idle();

    // R11: reset in the middle of a window
    beat(32'h800, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    beat_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(plan_valid == 1'b0, "R11", "plan cleared by reset", 32'(plan_valid), 32'd0);
    chk(rpt_valid == 1'b0, "R11", "rpt cleared by reset", 32'(rpt_valid), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      after_edge();
      chk(rpt_valid == 1'b0, "R11", $sformatf("no stale report c%0d", c), 32'(rpt_valid), 32'd0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule